// File: doc/BRIEF.md
# Zero-Overhead Counted Loop Controller

This block sits next to the program counter of an instruction fetch stage and repeats a body of code a fixed number of times, with no branch instruction inside the body. Software loads three values through a small register-write port: the address of the first body instruction, the address of the last body instruction, and how many times the body should run. Writing a nonzero iteration count arms the controller.

During every valid fetch, the block compares the fetch address with the stored last-body address. If they match and iterations remain, it decrements the count and steers the next fetch back to the first body address in the same cycle. On the final pass it lets fetch continue to the next sequential address and disarms itself. The next-PC output is combinational in the fetch address, so the redirect costs no extra cycle. The loop registers and the armed flag are clocked state.

Top module: `hwloop_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the loop is disarmed (`loop_active` = 0) and every valid fetch gets next address = fetch address + 1 with `loop_taken` = 0.
- R2: A write with `cfg_we` = 1 selects its register by `cfg_sel`: 0 = first body address, 1 = last body address, 2 = iteration count (low CNT_W bits of `cfg_wdata`). The new value is first used in the cycle after the write.
- R3: Writing a nonzero count sets `loop_active` on the next cycle. Writing a count of zero clears it, and the loop is then disabled.
- R4: When armed, with a valid fetch at the last body address and a remaining count above 1, `next_pc` equals the first body address and `loop_taken` = 1 in that same cycle, and the count drops by one.
- R5: When armed, with a valid fetch at the last body address and a remaining count of 1, `next_pc` is the last body address + 1, `loop_taken` = 0, and `loop_active` is 0 from the next cycle.
- R6: With a loaded count of N ≥ 1 and fetch following `next_pc`, the last body address is fetched exactly N times and `loop_taken` is asserted exactly N−1 times.
- R7: When no loop-back occurs on a valid fetch, `next_pc` = `fetch_pc` + 1 modulo 2^ADDR_W. When `fetch_valid` = 0, `next_pc` = `fetch_pc`, `loop_taken` = 0, and the count is left unchanged.
- R8: If a count write and a loop-back occur in the same cycle, the loop-back decision uses the old values and the written count replaces the decremented one.
- R9: A write with `cfg_sel` = 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 first, 1 last, 2 count, 3 none) |
| cfg_wdata | input | ADDR_W | Write data |
| fetch_valid | input | 1 | A fetch happens this cycle |
| fetch_pc | input | ADDR_W | Current fetch address |
| next_pc | output | ADDR_W | Address for the next fetch |
| loop_taken | output | 1 | Redirect to the first body address this cycle |
| loop_active | output | 1 | Loop armed |

## Verification
The hardest case to reach from the ports is a register write that lands in the very cycle the fetch address hits the last body address. The old and new values then disagree about the loop-back, and only the cycle after shows which one won. The bench drives the fetch address from the block's own `next_pc`, so it can step the loop to that exact cycle and issue the write there. It does this once for the count and once for the last body address. It also places a loop at the top of the address space, so the exit address wraps to zero.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  typedef enum logic [1:0] {
    REG_FIRST = 2'd0,
    REG_LAST  = 2'd1,
    REG_COUNT = 2'd2,
    REG_NONE  = 2'd3
  } loop_reg_e;
endpackage

// File: rtl/hwloop_regs.sv
module hwloop_regs
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              hit_end,
  input  logic              loop_back,
  output logic [ADDR_W-1:0] first_q,
  output logic [ADDR_W-1:0] last_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              active_q
);
  loop_reg_e sel;
  assign sel = loop_reg_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q  <= '0;
      last_q   <= '0;
      count_q  <= '0;
      active_q <= 1'b0;
    end else begin
      if (hit_end) begin
        if (loop_back) begin
          count_q <= count_q - CNT_W'(1);
        end else begin
          count_q  <= '0;
          active_q <= 1'b0;
        end
      end
      if (cfg_we) begin
        case (sel)
          REG_FIRST: first_q <= cfg_wdata;
          REG_LAST:  last_q  <= cfg_wdata;
          REG_COUNT: begin
            count_q  <= cfg_wdata[CNT_W-1:0];
            active_q <= |cfg_wdata[CNT_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hwloop_match.sv
module hwloop_match #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [ADDR_W-1:0] first_q,
  input  logic [ADDR_W-1:0] last_q,
  input  logic [CNT_W-1:0]  count_q,
  input  logic              active_q,
  output logic              hit_end,
  output logic              loop_back,
  output logic [ADDR_W-1:0] next_pc
);
  logic more_left;
  assign more_left = count_q > CNT_W'(1);
  assign hit_end   = fetch_valid & active_q & (fetch_pc == last_q);
  assign loop_back = hit_end & more_left;

  always_comb begin
    if (!fetch_valid)   next_pc = fetch_pc;
    else if (loop_back) next_pc = first_q;
    else                next_pc = fetch_pc + ADDR_W'(1);
  end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] next_pc,
  output logic              loop_taken,
  output logic              loop_active
);
  logic [ADDR_W-1:0] first_q;
  logic [ADDR_W-1:0] last_q;
  logic [CNT_W-1:0]  count_q;
  logic              active_q;
  logic              hit_end;
  logic              loop_back;

  hwloop_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .hit_end(hit_end), .loop_back(loop_back),
    .first_q(first_q), .last_q(last_q), .count_q(count_q), .active_q(active_q)
  );

  hwloop_match #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_match (
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .first_q(first_q),
    .last_q(last_q), .count_q(count_q), .active_q(active_q),
    .hit_end(hit_end), .loop_back(loop_back), .next_pc(next_pc)
  );

  assign loop_taken  = loop_back;
  assign loop_active = active_q;
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [ADDR_W-1:0] cfg_wdata,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic [ADDR_W-1:0] next_pc,
  input logic              loop_taken,
  input logic              loop_active,
  input logic [ADDR_W-1:0] first_q,
  input logic [ADDR_W-1:0] last_q,
  input logic [CNT_W-1:0]  count_q
);
  AST_RESET_DISARMS: assert property (@(posedge clk) rst |=> !loop_active); // R1
  AST_COUNT_ARMS: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd2 && cfg_wdata[CNT_W-1:0] != '0) |=> loop_active); // R3
  AST_ZERO_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd2 && cfg_wdata[CNT_W-1:0] == '0) |=> !loop_active); // R3
  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
    loop_taken |-> (loop_active && fetch_valid && fetch_pc == last_q && next_pc == first_q)); // R4
  AST_TAKEN_DECREMENTS: assert property (@(posedge clk) disable iff (rst)
    (loop_taken && !cfg_we) |=> count_q == $past(count_q) - CNT_W'(1)); // R4
  AST_LAST_PASS_EXITS: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && loop_active && fetch_pc == last_q && count_q == CNT_W'(1) && !cfg_we)
    |=> !loop_active); // R5
  AST_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !loop_taken) |-> next_pc == fetch_pc + ADDR_W'(1)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |-> (next_pc == fetch_pc && !loop_taken)); // R7
  AST_NONE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd3 && !fetch_valid)
    |=> ($stable(first_q) && $stable(last_q) && $stable(count_q) && $stable(loop_active))); // R9
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .next_pc(next_pc),
  .loop_taken(loop_taken), .loop_active(loop_active),
  .first_q(first_q), .last_q(last_q), .count_q(count_q)
);

// File: tb/hwloop_ctrl_tb_top.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic [15:0] next_pc;
  logic        loop_taken;
  logic        loop_active;

  always #2 clk = ~clk;

  hwloop_ctrl #(.ADDR_W(16), .CNT_W(8)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .loop_taken(loop_taken), .loop_active(loop_active)
  );

  int checks = 0;
  int errors = 0;
  // behavioural reference state
  int m_first = 0, m_last = 0, m_cnt = 0;
  bit m_act = 0;
  int obs_next = 0;
  bit obs_taken = 0;

  function automatic void chk(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // One clock: drive at negedge, compare just after, update model at edge.
  task automatic step(string tag, bit we, int sel, int wd, bit fv, int pc);
    int e_next;
    bit e_take;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel[1:0]; cfg_wdata = wd[15:0];
    fetch_valid = fv; fetch_pc = pc[15:0];
    #1;
    e_take = fv && m_act && pc == m_last && m_cnt > 1;
    e_next = !fv ? pc : (e_take ? m_first : ((pc + 1) & 16'hFFFF));
    chk({tag, " next_pc"}, int'(next_pc) == e_next, int'(next_pc), e_next);
    chk({tag, " loop_taken"}, loop_taken == e_take, int'(loop_taken), int'(e_take));
    chk({tag, " loop_active"}, loop_active == m_act, int'(loop_active), int'(m_act));
    obs_next = int'(next_pc);
    obs_taken = loop_taken;
    if (fv && m_act && pc == m_last) begin
      if (m_cnt > 1) m_cnt--;
      else begin m_cnt = 0; m_act = 0; end
    end
    if (we) begin
      case (sel)
        0: m_first = wd & 16'hFFFF;
        1: m_last  = wd & 16'hFFFF;
        2: begin m_cnt = wd & 8'hFF; m_act = (m_cnt != 0); end
        default: ;
      endcase
    end
  endtask

  task automatic wr(string tag, int sel, int wd);
    step(tag, 1'b1, sel, wd, 1'b0, 0);
  endtask

  // Fetch follows next_pc from start until exit; counts end hits and takens.
  task automatic run_loop(string tag, int start, int last, int n, int limit);
    int pc = start;
    int hits = 0;
    int takes = 0;
    for (int i = 0; i < limit; i++) begin
      if (pc == last) hits++;
      step(tag, 1'b0, 0, 0, 1'b1, pc);
      if (obs_taken) takes++;
      if (pc == last && !obs_taken) break;
      pc = obs_next;
    end
    chk({tag, " R6 end fetches"}, hits == n, hits, n);
    chk({tag, " R6 takens"}, takes == n - 1, takes, n - 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 armed in reset", loop_active == 1'b0, int'(loop_active), 0);
    rst = 1'b0;
    step("R1", 0, 0, 0, 1, 16'h0000);
    step("R1", 0, 0, 0, 1, 16'h0001);

    // R2 R4 R5 R6: three-pass loop
    wr("R2", 0, 16'h0010);
    wr("R2", 1, 16'h0013);
    wr("R3", 2, 3);
    run_loop("R4", 16'h0010, 16'h0013, 3, 40);
    step("R5 after exit", 0, 0, 0, 1, 16'h0014);

    // R5: single pass
    wr("R3", 2, 1);
    run_loop("R5", 16'h0010, 16'h0013, 1, 20);

    // R3: zero count disarms
    wr("R3", 2, 4);
    wr("R3", 2, 0);
    step("R3 disarmed", 0, 0, 0, 1, 16'h0013);

    // R9: select 3 changes nothing
    wr("R3", 2, 2);
    wr("R9", 3, 16'h0013);
    step("R9", 0, 0, 0, 0, 16'h0013);
    run_loop("R9", 16'h0010, 16'h0013, 2, 20);

    // R7: stalled fetch at end address leaves count alone
    wr("R3", 2, 2);
    step("R7 stall", 0, 0, 0, 0, 16'h0013);
    step("R7 stall", 0, 0, 0, 0, 16'h0013);
    run_loop("R7", 16'h0010, 16'h0013, 2, 20);

    // R8: count write coincident with loop-back
    wr("R3", 2, 5);
    step("R8 coincide", 1, 2, 2, 1, 16'h0013);
    chk("R8 taken on old count", obs_taken == 1'b1, int'(obs_taken), 1);
    run_loop("R8", 16'h0010, 16'h0013, 2, 20);

    // R2: end address write coincident with a fetch at the new address
    wr("R3", 2, 3);
    step("R2 old end", 1, 1, 16'h0020, 1, 16'h0020);
    chk("R2 write not yet used", obs_taken == 1'b0, int'(obs_taken), 0);
    step("R2 new end", 0, 0, 0, 1, 16'h0020);
    chk("R2 write used next cycle", obs_taken == 1'b1, int'(obs_taken), 1);

    // R7: wrap at top of address space
    wr("R2", 0, 16'hFFF0);
    wr("R2", 1, 16'hFFFF);
    wr("R3", 2, 2);
    run_loop("R7 wrap", 16'hFFF0, 16'hFFFF, 2, 40);
    chk("R7 wrap exit", obs_next == 0, obs_next, 0);

    // R6: long count
    wr("R2", 0, 16'h0100);
    wr("R2", 1, 16'h0101);
    wr("R3", 2, 200);
    run_loop("R6 long", 16'h0100, 16'h0101, 200, 1000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule